// File: doc/BRIEF.md
# Montgomery Ladder Scalar Multiplication Sequencer

This block drives scalar point multiplication Q = k·P over a binary field with a 163-bit scalar. It follows the Montgomery ladder and does no field or curve arithmetic itself. Instead, it sends a stream of commands to an external arithmetic-unit controller. Each command names an operation, a source register slot and a destination register slot. The block holds each command until the controller returns a one-cycle done pulse.

After a start request, the sequencer first skips the scalar's leading zero bits, one per cycle. It then seeds the two working points: slot ACC0 gets the base point P and slot ACC1 gets 2P. For every bit below the leading one, it issues exactly one addition and one doubling. The key bit only chooses which working slot is read and which is written. The number and kind of operations therefore depend only on the position of the leading one, not on the values of the lower bits. When the last command completes, slot ACC0 holds k·P and the block pulses `ready_o`. A zero scalar is refused with an error pulse and no commands.

Top module: `ladder_seq`

## Requirements
- R1: While reset is high and in the cycle after it is released, `busy_o`, `cmd_valid_o`, `ready_o` and `zero_err_o` are all 0.
- R2: A start with a zero scalar while idle raises `zero_err_o` for exactly one cycle, starting in the cycle after the start. No command is issued and `busy_o` stays 0.
- R3: A start request while `busy_o` is 1 is ignored. The running multiplication keeps its command stream and its result.
- R4: After leading zeros are skipped, the first two commands are always the seed pair:
  - LOAD (op 0) from slot BASE (0) into slot ACC0 (1).
  - DBL (op 2) from BASE into slot ACC1 (2).
- R5: For a key bit of 1, the sequencer issues ADD (op 1) with src ACC1 and dst ACC0, then DBL with src ACC1 and dst ACC1.
- R6: For a key bit of 0, the sequencer issues ADD with src ACC0 and dst ACC1, then DBL with src ACC0 and dst ACC0.
- R7: A command's op, src and dst stay stable while `cmd_valid_o` is 1 until `cmd_done_i` is seen. A done pulse while no command is valid has no effect.
- R8: A scalar whose highest set bit has index m produces exactly 2 + 2·m commands, whatever the lower bits are. Key bits are taken from index m−1 down to 0.
- R9: One cycle after the final done, `ready_o` is 1 for exactly one cycle. With the slot semantics below, slot ACC0 then holds k·P:
  - LOAD: dst ← src.
  - ADD: dst ← dst + src.
  - DBL: dst ← 2·src.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled while idle |
| scalar_i | input | KEY_W | Scalar k, sampled with start_i |
| cmd_valid_o | output | 1 | A command is presented |
| cmd_op_o | output | 2 | Operation: 0 LOAD, 1 ADD, 2 DBL |
| cmd_src_o | output | 2 | Source slot: 0 BASE, 1 ACC0, 2 ACC1 |
| cmd_dst_o | output | 2 | Destination slot |
| cmd_done_i | input | 1 | One-cycle completion pulse from the arithmetic controller |
| busy_o | output | 1 | A multiplication is in progress |
| ready_o | output | 1 | One-cycle pulse: result is in ACC0 |
| zero_err_o | output | 1 | One-cycle pulse: zero scalar refused |

## Verification
The assertions check the following on every cycle:
- A pending command stays frozen until done.
- A command is never valid while idle and never targets the base slot.
- Ready and the zero error are single, mutually exclusive pulses, and ready only follows a completion.
- A zero start produces only the error pulse.

The bench's scenarios are needed for everything else:
- The exact ADD/DBL slot choice per key bit.
- The leading-zero skip and the resulting command count.
- Ignoring a start while busy.
- The arithmetic correctness of the final ACC0 value.

The bench shows these by replaying each command on integer multiples of P and comparing the result to k.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_ADD  = 2'd1,
        OP_DBL  = 2'd2
    } lad_op_e;

    typedef enum logic [1:0] {
        SL_BASE = 2'd0,
        SL_ACC0 = 2'd1,
        SL_ACC1 = 2'd2
    } lad_slot_e;

    typedef struct packed {
        lad_op_e   op;
        lad_slot_e src;
        lad_slot_e dst;
    } lad_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM,
        ST_SEED,
        ST_TWICE,
        ST_SUM,
        ST_DUP,
        ST_FIN
    } lad_state_e;

    typedef enum logic [1:0] {
        PH_SEED,
        PH_TWICE,
        PH_SUM,
        PH_DUP
    } lad_phase_e;

    // Command for a ladder phase; kbit selects which accumulator leads.
    function automatic lad_cmd_t ladder_cmd(input lad_phase_e ph, input logic kbit);
        lad_cmd_t c;
        lad_slot_e lead;
        lad_slot_e other;
        lead  = kbit ? SL_ACC1 : SL_ACC0;
        other = kbit ? SL_ACC0 : SL_ACC1;
        case (ph)
            PH_SEED:  c = '{op: OP_LOAD, src: SL_BASE, dst: SL_ACC0};
            PH_TWICE: c = '{op: OP_DBL,  src: SL_BASE, dst: SL_ACC1};
            PH_SUM:   c = '{op: OP_ADD,  src: lead,    dst: other};
            default:  c = '{op: OP_DBL,  src: lead,    dst: lead};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ladder_keyreg.sv
module ladder_keyreg #(
    parameter int KEY_W = 163,
    parameter int CNT_W = $clog2(KEY_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [KEY_W-1:0] scalar_i,
    input  logic             shift_i,
    output logic             top_o,
    output logic             cur_o,
    output logic [CNT_W-1:0] left_o
);

    logic [KEY_W-1:0] key_q;
    logic [CNT_W-1:0] cnt_q;

    // Left-shifting register: the top bit marks normalisation, the next one
    // is the key bit being processed; cnt_q counts bits still below the top.
    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            key_q <= scalar_i;
            cnt_q <= CNT_W'(KEY_W - 1);
        end else if (shift_i) begin
            key_q <= {key_q[KEY_W-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign top_o  = key_q[KEY_W-1];
    assign cur_o  = key_q[KEY_W-2];
    assign left_o = cnt_q;

endmodule

// File: rtl/ladder_cmd_map.sv
module ladder_cmd_map
    import ladder_pkg::*;
(
    input  lad_state_e state_i,
    input  logic       kbit_i,
    output logic       valid_o,
    output lad_cmd_t   cmd_o
);

    lad_phase_e ph;

    always_comb begin
        valid_o = 1'b1;
        case (state_i)
            ST_SEED:  ph = PH_SEED;
            ST_TWICE: ph = PH_TWICE;
            ST_SUM:   ph = PH_SUM;
            ST_DUP:   ph = PH_DUP;
            default: begin
                ph      = PH_SEED;
                valid_o = 1'b0;
            end
        endcase
        cmd_o = ladder_cmd(ph, kbit_i);
    end

endmodule

// File: rtl/ladder_seq.sv
module ladder_seq
    import ladder_pkg::*;
#(
    parameter int KEY_W = 163
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [KEY_W-1:0] scalar_i,
    output logic             cmd_valid_o,
    output logic [1:0]       cmd_op_o,
    output logic [1:0]       cmd_src_o,
    output logic [1:0]       cmd_dst_o,
    input  logic             cmd_done_i,
    output logic             busy_o,
    output logic             ready_o,
    output logic             zero_err_o
);

    localparam int CNT_W = $clog2(KEY_W);

    lad_state_e       state_q, state_d;
    logic             zero_q;
    logic             key_load, key_shift;
    logic             key_top, key_cur;
    logic [CNT_W-1:0] key_left;
    logic             map_valid;
    lad_cmd_t         map_cmd;
    logic             accept, is_zero;

    assign is_zero = (scalar_i == '0);
    assign accept  = (state_q == ST_IDLE) && start_i;

    assign key_load  = accept && !is_zero;
    assign key_shift = ((state_q == ST_NORM) && !key_top) ||
                       ((state_q == ST_DUP)  && cmd_done_i);

    ladder_keyreg #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_key (
        .clk      (clk),
        .rst      (rst),
        .load_i   (key_load),
        .scalar_i (scalar_i),
        .shift_i  (key_shift),
        .top_o    (key_top),
        .cur_o    (key_cur),
        .left_o   (key_left)
    );

    ladder_cmd_map u_map (
        .state_i (state_q),
        .kbit_i  (key_cur),
        .valid_o (map_valid),
        .cmd_o   (map_cmd)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (key_load)   state_d = ST_NORM;
            ST_NORM:  if (key_top)    state_d = ST_SEED;
            ST_SEED:  if (cmd_done_i) state_d = ST_TWICE;
            ST_TWICE: if (cmd_done_i) state_d = (key_left == '0) ? ST_FIN : ST_SUM;
            ST_SUM:   if (cmd_done_i) state_d = ST_DUP;
            ST_DUP:   if (cmd_done_i) state_d = (key_left == CNT_W'(1)) ? ST_FIN : ST_SUM;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            zero_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            zero_q  <= accept && is_zero;
        end
    end

    assign cmd_valid_o = map_valid;
    assign cmd_op_o    = map_cmd.op;
    assign cmd_src_o   = map_cmd.src;
    assign cmd_dst_o   = map_cmd.dst;
    assign busy_o      = (state_q != ST_IDLE);
    assign ready_o     = (state_q == ST_FIN);
    assign zero_err_o  = zero_q;

endmodule

// File: rtl/ladder_seq_chk.sv
module ladder_seq_chk #(
    parameter int KEY_W = 163
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [KEY_W-1:0] scalar_i,
    input logic             cmd_valid_o,
    input logic [1:0]       cmd_op_o,
    input logic [1:0]       cmd_src_o,
    input logic [1:0]       cmd_dst_o,
    input logic             cmd_done_i,
    input logic             busy_o,
    input logic             ready_o,
    input logic             zero_err_o
);

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && !cmd_done_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_src_o) && $stable(cmd_dst_o))); // R7

    AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> busy_o); // R7

    AST_NO_BASE_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> (cmd_dst_o != 2'd0)); // R4

    AST_ZERO_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && (scalar_i == '0)) |=> (zero_err_o && !busy_o && !cmd_valid_o)); // R2

    AST_ZERO_PULSE: assert property (@(posedge clk) disable iff (rst)
        zero_err_o |=> !zero_err_o); // R2

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> !ready_o); // R9

    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> ($past(cmd_done_i) && !cmd_valid_o)); // R9

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ready_o, zero_err_o})); // R9

endmodule

bind ladder_seq ladder_seq_chk #(.KEY_W(KEY_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .scalar_i    (scalar_i),
    .cmd_valid_o (cmd_valid_o),
    .cmd_op_o    (cmd_op_o),
    .cmd_src_o   (cmd_src_o),
    .cmd_dst_o   (cmd_dst_o),
    .cmd_done_i  (cmd_done_i),
    .busy_o      (busy_o),
    .ready_o     (ready_o),
    .zero_err_o  (zero_err_o)
);

// File: tb/test_ladder_seq.sv
module test_ladder_seq;

    localparam int KW = 163;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [KW-1:0] scalar_i = '0;
    logic          cmd_valid_o;
    logic [1:0]    cmd_op_o, cmd_src_o, cmd_dst_o;
    logic          cmd_done_i;
    logic          resp_done = 1'b0;
    logic          poke_done = 1'b0;
    logic          busy_o, ready_o, zero_err_o;

    assign cmd_done_i = resp_done | poke_done;

    always #10 clk = ~clk;

    ladder_seq #(.KEY_W(KW)) i_ladder_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .scalar_i    (scalar_i),
        .cmd_valid_o (cmd_valid_o),
        .cmd_op_o    (cmd_op_o),
        .cmd_src_o   (cmd_src_o),
        .cmd_dst_o   (cmd_dst_o),
        .cmd_done_i  (cmd_done_i),
        .busy_o      (busy_o),
        .ready_o     (ready_o),
        .zero_err_o  (zero_err_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_cmd = 0;
    int lat   = 0;

    logic [5:0]   exp_q[$];
    string        tag_q[$];
    logic [191:0] slot[3];

    task automatic check(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Driver side: independent ladder walk producing the expected command list.
    task automatic push_expected(input logic [KW-1:0] k, output int count);
        int m;
        m = 0;
        for (int i = 0; i < KW; i++) if (k[i]) m = i;
        exp_q.push_back({2'd0, 2'd0, 2'd1}); tag_q.push_back("R4 seed load");
        exp_q.push_back({2'd2, 2'd0, 2'd2}); tag_q.push_back("R4 seed double");
        for (int i = m - 1; i >= 0; i--) begin
            if (k[i]) begin
                exp_q.push_back({2'd1, 2'd2, 2'd1}); tag_q.push_back("R5 add");
                exp_q.push_back({2'd2, 2'd2, 2'd2}); tag_q.push_back("R5 double");
            end else begin
                exp_q.push_back({2'd1, 2'd1, 2'd2}); tag_q.push_back("R6 add");
                exp_q.push_back({2'd2, 2'd1, 2'd1}); tag_q.push_back("R6 double");
            end
        end
        count = 2 + 2 * m;
    endtask

    // Monitor and arithmetic model: pops, compares, applies, answers done.
    initial begin
        logic [5:0] got, e;
        string t;
        forever begin
            @(negedge clk);
            if (cmd_valid_o && !rst) begin
                got = {cmd_op_o, cmd_src_o, cmd_dst_o};
                n_cmd++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 extra command", 192'(got), 192'd0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(got == e, t, 192'(got), 192'(e));
                end
                case (cmd_op_o)
                    2'd0:    slot[cmd_dst_o] = slot[cmd_src_o];
                    2'd1:    slot[cmd_dst_o] = slot[cmd_dst_o] + slot[cmd_src_o];
                    default: slot[cmd_dst_o] = slot[cmd_src_o] << 1;
                endcase
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    check(cmd_valid_o && ({cmd_op_o, cmd_src_o, cmd_dst_o} == got),
                          "R7 held", 192'({cmd_valid_o, cmd_op_o, cmd_src_o, cmd_dst_o}), 192'({1'b1, got}));
                end
                resp_done = 1'b1;
                @(negedge clk);
                resp_done = 1'b0;
            end
        end
    end

    task automatic run(input logic [KW-1:0] k, input int latency, input bit poke);
        int  expn;
        bit  seen;
        lat = latency;
        exp_q.delete();
        tag_q.delete();
        push_expected(k, expn);
        slot[0] = 192'd1; slot[1] = '0; slot[2] = '0;
        n_cmd = 0;
        @(negedge clk);
        start_i  = 1'b1;
        scalar_i = k;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            // R3: a second start while busy must change nothing
            start_i  = 1'b1;
            scalar_i = {KW{1'b1}};
            @(negedge clk);
            start_i  = 1'b0;
        end
        seen = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            if (ready_o) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        check(seen, "R9 ready seen", 192'(seen), 192'd1);
        check(slot[1] == 192'(k), "R9 ACC0 equals k*P", slot[1], 192'(k));
        check(n_cmd == expn, "R8 command count", 192'(n_cmd), 192'(expn));
        check(exp_q.size() == 0, "R8 all expected issued", 192'(exp_q.size()), 192'd0);
        @(negedge clk);
        check(!ready_o && !busy_o, "R9 ready single pulse", 192'({ready_o, busy_o}), 192'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check({busy_o, cmd_valid_o, ready_o, zero_err_o} == 4'b0, "R1 during reset",
              192'({busy_o, cmd_valid_o, ready_o, zero_err_o}), 192'd0);
        rst = 1'b0;
        @(negedge clk);
        check({busy_o, cmd_valid_o, ready_o, zero_err_o} == 4'b0, "R1 after reset",
              192'({busy_o, cmd_valid_o, ready_o, zero_err_o}), 192'd0);

        // R2 zero scalar
        n_cmd = 0;
        start_i = 1'b1; scalar_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        check(zero_err_o, "R2 error raised", 192'(zero_err_o), 192'd1);
        check(!busy_o && !cmd_valid_o, "R2 stays idle", 192'({busy_o, cmd_valid_o}), 192'd0);
        @(negedge clk);
        check(!zero_err_o, "R2 error one cycle", 192'(zero_err_o), 192'd0);
        repeat (3) @(negedge clk);
        check(n_cmd == 0 && !busy_o, "R2 no commands", 192'(n_cmd), 192'd0);

        // R7 done while idle has no effect
        poke_done = 1'b1;
        repeat (2) @(negedge clk);
        poke_done = 1'b0;
        check(!cmd_valid_o && !busy_o && !ready_o, "R7 stray done ignored",
              192'({cmd_valid_o, busy_o, ready_o}), 192'd0);

        run(KW'(1), 0, 1'b0);                     // R8 seed only
        run(KW'(11), 1, 1'b0);                    // R5 and R6 mixed
        run({KW{1'b1}}, 0, 1'b0);                 // R5 all ones, R8 full length
        run({1'b1, {(KW-1){1'b0}}}, 0, 1'b0);     // R6 all zeros below top, R8
        run(KW'(192'h5a5a_0f0f_3c3c_9999_1234_5678_abcd), 2, 1'b0);
        run(KW'(5), 2, 1'b1);                     // R3 start while busy
        run(KW'(2), 1, 1'b0);                     // R6 single step

        summary();
    end

endmodule